// File: doc/BRIEF.md
# Opcode-menu SPI flash sequencer

This block is a register-programmed master for SPI NOR flash. It runs one flash cycle for each GO command. Software fills an eight-entry table of one-byte opcodes and a packed table of two-bit types, one per entry. It also loads a pair of prefix opcodes, a flash address and a data buffer of up to 64 bytes. A GO write to the control register names a table entry by index. The block then sends that entry's opcode on a single-bit SPI bus in mode 0. The entry's type decides whether a 24-bit address follows and in which direction the optional data phase moves bytes.

A prefix opcode, such as a write enable, can be requested with the command. It goes out as its own chip-select frame just before the main frame, and the block stays busy across both frames, so no other cycle can run between them. Software may set a lock bit in the status register. The lock bit stays set until reset and freezes the prefix, type and opcode tables. While locked, a GO whose requested data direction does not match the selected entry's type is refused with an error and no bus activity. A speed bit in the control word selects the shorter of two SCK half-periods.

Top module: `opmenu_spi_seq`

## Requirements
- R1: After reset, the status register reads 0, spi_csn is high, and spi_sck and spi_mosi are low.
- R2: A control write with bit 0 set (GO) starts a cycle using the opcode of the table entry named by bits 6:4. In the control word, bit 1 enables the prefix, bit 2 selects the prefix opcode, bit 3 selects the fast clock, bits 13:8 hold the byte count minus one, bit 14 enables the data phase and bit 15 requests write direction. Busy (status bit 0) and a low spi_csn appear on the first clock edge after GO. Bits are sent MSB first in SPI mode 0: SCK idles low, MOSI changes only while SCK is low and holds while SCK is high, and the target samples on the rising edge.
- R3: Each entry has a 2-bit type at bits 2i+1:2i of the type register. Type bit 1 means the frame carries an address and type bit 0 means write direction: 0 is read with no address, 1 is write with no address, 2 is read with address and 3 is write with address. The address is the low 24 bits of the address register, sent MSB first after the opcode. Upper written bits are ignored and read back as 0.
- R4: With the data phase enabled, count+1 bytes (1 to 64) follow the header. A write sends buffer bytes from byte 0, each MSB first. A read captures MISO into the buffer from byte 0, MSB first. Buffer word w at register 16+w holds bytes 4w to 4w+3, with the lowest byte in bits 7:0.
- R5: Done (status bit 1) is set, and busy falls, on the same edge where spi_csn returns high at the end of the main frame. Writing 1 to status bit 1 or bit 2 clears done or error.
- R6: A GO written while busy is ignored: the cycle in progress runs unchanged and no extra frame follows.
- R7: With the prefix enabled, an 8-bit frame carrying the prefix opcode (register 3, bits 7:0 when bit 2 is 0 and bits 15:8 when bit 2 is 1) is sent first. spi_csn stays high for exactly one SCK half-period before the main frame begins.
- R8: Writing 1 to status bit 3 sets the lock, which stays set until reset. While locked, writes to the prefix (3), type (4) and opcode table (5 for entries 0 to 3, 6 for entries 4 to 7, entry 4k+j in bits 8j+7:8j) are ignored.
- R9: While locked, a GO with the data phase enabled and a write-direction bit different from the selected type's bit 0 sets error on the next edge, leaves busy low and produces no SPI frame.
- R10: The SCK high time is DIV_SLOW system clocks, or DIV_FAST clocks when control bit 3 was set at GO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 5 | Register address (16 to 31 select buffer words) |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| spi_sck | output | 1 | SPI serial clock, idles low |
| spi_csn | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench targets the edges of the bit counter. A 64-byte write checks that the data phase is not cut off early, and a design with a short length field would end the frame after fewer bits. Single-byte reads check that the captured bits land in byte 0 MSB first, which would break if the capture bit order were reversed. A GO during a busy cycle is checked against a second frame appearing or the opcode changing mid-frame. The prefix case measures the chip-select gap and the prefix byte selection, so an off-by-one in the gap state or a swapped prefix select shows up. Under lock, a direction clash must leave the bus silent and the tables must read back unchanged, so a design that still starts the cycle or lets a table write through would fail.

// File: rtl/osq_pkg.sv
`timescale 1ns/1ps
package osq_pkg;
  localparam int MENU_N = 8;
  localparam int IDX_W  = $clog2(MENU_N);
  localparam int OP_W   = 8;
  localparam int FADDR_W = 24;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_GAP, S_MAIN} seq_state_e;

  // type bit 1: address phase present, bit 0: write direction
  function automatic int unsigned hdr_bits(input logic [1:0] t);
    return t[1] ? OP_W + FADDR_W : OP_W;
  endfunction

  function automatic int unsigned main_bits(input logic [1:0] t, input logic dat,
                                            input int unsigned nbytes);
    return hdr_bits(t) + (dat ? nbytes * 8 : 0);
  endfunction
endpackage

// File: rtl/osq_cfg.sv
`timescale 1ns/1ps
module osq_cfg import osq_pkg::*; (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_prefix,
  input  logic                   wr_types,
  input  logic                   wr_menu_lo,
  input  logic                   wr_menu_hi,
  input  logic                   lock_set,
  input  logic [31:0]            wdata,
  output logic [15:0]            prefix,
  output logic [2*MENU_N-1:0]    types,
  output logic [OP_W*MENU_N-1:0] menu,
  output logic                   locked
);
  localparam int HALF = OP_W * MENU_N / 2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prefix <= '0;
      types  <= '0;
      menu   <= '0;
      locked <= 1'b0;
    end else begin
      if (lock_set) locked <= 1'b1;
      if (!locked) begin
        if (wr_prefix)  prefix <= wdata[15:0];
        if (wr_types)   types  <= wdata[2*MENU_N-1:0];
        if (wr_menu_lo) menu[HALF-1:0]      <= wdata[HALF-1:0];
        if (wr_menu_hi) menu[2*HALF-1:HALF] <= wdata[HALF-1:0];
      end
    end
  end
endmodule

// File: rtl/osq_sckgen.sv
`timescale 1ns/1ps
module osq_sckgen #(
  parameter int DIV_SLOW = 4,
  parameter int DIV_FAST = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fast,
  output logic tick
);
  localparam int DMAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? CW'(DIV_FAST) : CW'(DIV_SLOW);
  assign tick = en && (cnt == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!en)  cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/osq_databuf.sv
`timescale 1ns/1ps
module osq_databuf #(
  parameter int BYTES = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sw_we,
  input  logic [$clog2(BYTES/4)-1:0] sw_word,
  input  logic [31:0]                sw_wdata,
  output logic [31:0]                sw_rdata,
  input  logic [$clog2(BYTES)-1:0]   eng_byte,
  output logic [7:0]                 eng_rbyte,
  input  logic                       eng_bit_we,
  input  logic [2:0]                 eng_bit_pos,
  input  logic                       eng_bit_val
);
  localparam int BA_W = $clog2(BYTES);

  logic [7:0] mem [BYTES];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    localparam logic [1:0] LANE = 2'(g);
    assign sw_rdata[8*g +: 8] = mem[{sw_word, LANE}];
  end

  assign eng_rbyte = mem[eng_byte];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
    end else if (sw_we) begin
      for (int i = 0; i < 4; i++) mem[BA_W'({sw_word, 2'(i)})] <= sw_wdata[8*i +: 8];
    end else if (eng_bit_we) begin
      mem[eng_byte][eng_bit_pos] <= eng_bit_val;
    end
  end
endmodule

// File: rtl/opmenu_spi_seq.sv
`timescale 1ns/1ps
module opmenu_spi_seq import osq_pkg::*; #(
  parameter int BUF_BYTES = 64,
  parameter int DIV_SLOW  = 4,
  parameter int DIV_FAST  = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [$clog2(BUF_BYTES/4):0]         reg_addr,
  input  logic [31:0]                          reg_wdata,
  input  logic                                 reg_we,
  output logic [31:0]                          reg_rdata,
  output logic                                 spi_sck,
  output logic                                 spi_csn,
  output logic                                 spi_mosi,
  input  logic                                 spi_miso
);
  localparam int WA_W  = $clog2(BUF_BYTES / 4);
  localparam int RA_W  = WA_W + 1;
  localparam int CNT_W = $clog2(BUF_BYTES);
  localparam int BIT_W = $clog2(OP_W + FADDR_W + 8 * BUF_BYTES + 1);
  localparam logic [RA_W-1:0] A_CTRL = RA_W'(0), A_ADDR = RA_W'(1), A_STAT = RA_W'(2),
                              A_PFX = RA_W'(3), A_TYPE = RA_W'(4), A_MLO = RA_W'(5),
                              A_MHI = RA_W'(6);

  // configuration tables
  logic [15:0]            prefix;
  logic [2*MENU_N-1:0]    types;
  logic [OP_W*MENU_N-1:0] menu;
  logic                   locked;
  logic [FADDR_W-1:0]     addr_r;

  logic wr_ctrl, wr_stat, wr_data;
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_stat = reg_we && (reg_addr == A_STAT);

  osq_cfg u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_prefix(reg_we && reg_addr == A_PFX), .wr_types(reg_we && reg_addr == A_TYPE),
    .wr_menu_lo(reg_we && reg_addr == A_MLO), .wr_menu_hi(reg_we && reg_addr == A_MHI),
    .lock_set(wr_stat && reg_wdata[3]), .wdata(reg_wdata),
    .prefix(prefix), .types(types), .menu(menu), .locked(locked)
  );

  // sequencer state
  seq_state_e         state;
  logic [BIT_W-1:0]   bitn;
  logic               sck_q, csn_q, done_q, err_q;
  logic [OP_W-1:0]    op_q, pfxop_q;
  logic [1:0]         typ_q;
  logic [FADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               dat_q, fast_q;
  logic               busy, tick;

  assign busy = (state != S_IDLE);

  // GO decode
  logic [IDX_W-1:0] sel_idx;
  logic [1:0]       sel_type;
  logic             go_wr, go_ok, go_bad, dir_clash;
  assign sel_idx   = reg_wdata[4 +: IDX_W];
  assign sel_type  = types[2*sel_idx +: 2];
  assign go_wr     = wr_ctrl && reg_wdata[0];
  assign dir_clash = reg_wdata[14] && (sel_type[0] != reg_wdata[15]);
  assign go_bad    = go_wr && !busy && locked && dir_clash;
  assign go_ok     = go_wr && !busy && !go_bad;

  // frame arithmetic
  logic [BIT_W-1:0] hdr, last_bit, doff;
  logic             in_data, frame_end, main_end, cur_bit;
  logic [4:0]       aidx;
  logic [7:0]       eng_rbyte;
  assign hdr       = BIT_W'(hdr_bits(typ_q));
  assign last_bit  = (state == S_PRE) ? BIT_W'(OP_W - 1)
                   : BIT_W'(main_bits(typ_q, dat_q, int'(cnt_q) + 1) - 1);
  assign in_data   = (state == S_MAIN) && (bitn >= hdr);
  assign doff      = bitn - hdr;
  assign aidx      = 5'(BIT_W'(OP_W + FADDR_W - 1) - bitn);
  assign frame_end = tick && sck_q && (bitn == last_bit) && (state == S_PRE || state == S_MAIN);
  assign main_end  = frame_end && (state == S_MAIN);

  always_comb begin
    cur_bit = 1'b0;
    if (state == S_PRE)             cur_bit = pfxop_q[~bitn[2:0]];
    else if (state == S_MAIN) begin
      if (bitn < BIT_W'(OP_W))      cur_bit = op_q[~bitn[2:0]];
      else if (!in_data)            cur_bit = addr_q[aidx];
      else                          cur_bit = typ_q[0] && eng_rbyte[~doff[2:0]];
    end
  end

  osq_sckgen #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_sck (
    .clk(clk), .rst_n(rst_n), .en(busy), .fast(fast_q), .tick(tick)
  );

  logic [31:0] buf_rdata;
  assign wr_data = reg_we && reg_addr[RA_W-1] && !busy;

  osq_databuf #(.BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .sw_we(wr_data), .sw_word(reg_addr[WA_W-1:0]), .sw_wdata(reg_wdata), .sw_rdata(buf_rdata),
    .eng_byte(CNT_W'(doff >> 3)), .eng_rbyte(eng_rbyte),
    .eng_bit_we(tick && !sck_q && in_data && !typ_q[0]),
    .eng_bit_pos(~doff[2:0]), .eng_bit_val(spi_miso)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_r <= '0;
    else if (reg_we && reg_addr == A_ADDR) addr_r <= reg_wdata[FADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bitn <= '0; sck_q <= 1'b0; csn_q <= 1'b1;
      op_q <= '0; pfxop_q <= '0; typ_q <= '0; addr_q <= '0;
      cnt_q <= '0; dat_q <= 1'b0; fast_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (go_ok) begin
          op_q    <= menu[OP_W*sel_idx +: OP_W];
          typ_q   <= sel_type;
          addr_q  <= addr_r;
          cnt_q   <= reg_wdata[8 +: CNT_W];
          dat_q   <= reg_wdata[14];
          fast_q  <= reg_wdata[3];
          pfxop_q <= reg_wdata[2] ? prefix[15:8] : prefix[7:0];
          bitn    <= '0;
          csn_q   <= 1'b0;
          state   <= reg_wdata[1] ? S_PRE : S_MAIN;
        end
        S_PRE, S_MAIN: if (tick) begin
          if (!sck_q) sck_q <= 1'b1;
          else begin
            sck_q <= 1'b0;
            if (bitn == last_bit) begin
              csn_q <= 1'b1;
              bitn  <= '0;
              state <= (state == S_PRE) ? S_GAP : S_IDLE;
            end else begin
              bitn <= bitn + BIT_W'(1);
            end
          end
        end
        S_GAP: if (tick) begin
          csn_q <= 1'b0;
          state <= S_MAIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      if (main_end)                     done_q <= 1'b1;
      else if (wr_stat && reg_wdata[1]) done_q <= 1'b0;
      if (go_bad)                       err_q <= 1'b1;
      else if (wr_stat && reg_wdata[2]) err_q <= 1'b0;
    end
  end

  assign spi_sck  = sck_q;
  assign spi_csn  = csn_q;
  assign spi_mosi = !csn_q && cur_bit;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[RA_W-1]) reg_rdata = buf_rdata;
    else unique case (reg_addr)
      A_ADDR:  reg_rdata = 32'(addr_r);
      A_STAT:  reg_rdata = {28'd0, locked, err_q, done_q, busy};
      A_PFX:   reg_rdata = 32'(prefix);
      A_TYPE:  reg_rdata = 32'(types);
      A_MLO:   reg_rdata = menu[31:0];
      A_MHI:   reg_rdata = menu[63:32];
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/osq_checker.sv
`timescale 1ns/1ps
module osq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       csn,
  input logic       sck,
  input logic       mosi,
  input logic       done,
  input logic       err,
  input logic       locked,
  input logic       go_wr,
  input logic       go_ok,
  input logic       go_bad,
  input logic [7:0] cmd_op
);
  assert_busy_after_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_ok |=> (busy && !csn));

  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> !sck);

  assert_mosi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi));

  assert_cs_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> csn);

  assert_done_at_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($rose(csn) && !busy));

  assert_go_busy_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go_wr && busy) |=> $stable(cmd_op));

  assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> locked);

  assert_clash_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    go_bad |=> (!busy && err && csn));
endmodule

bind opmenu_spi_seq osq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .csn(spi_csn), .sck(spi_sck), .mosi(spi_mosi),
  .done(done_q), .err(err_q), .locked(locked), .go_wr(go_wr), .go_ok(go_ok),
  .go_bad(go_bad), .cmd_op(op_q)
);

// File: tb/test_opmenu_spi_seq.sv
`timescale 1ns/1ps
module test_opmenu_spi_seq;
  localparam int DIV_SLOW = 4, DIV_FAST = 2;
  localparam logic [4:0] A_CTRL = 0, A_ADDR = 1, A_STAT = 2, A_PFX = 3, A_TYPE = 4,
                         A_MLO = 5, A_MHI = 6;
  localparam logic [23:0] FADDR = 24'h123456;
  // idx[9:7], cnt[6:1], dat[0]
  localparam logic [9:0] VECS [8] = '{
    {3'd0, 6'd3, 1'b1}, {3'd1, 6'd7, 1'b1}, {3'd4, 6'd2, 1'b1}, {3'd5, 6'd0, 1'b0},
    {3'd6, 6'd0, 1'b0}, {3'd1, 6'd63, 1'b1}, {3'd2, 6'd0, 1'b1}, {3'd3, 6'd1, 1'b1}};
  localparam logic [7:0] MENU [8] = '{8'h03, 8'h02, 8'h05, 8'h01, 8'h9F, 8'h20, 8'h06, 8'hAB};
  localparam logic [1:0] TYPES [8] = '{2'd2, 2'd3, 2'd0, 2'd1, 2'd0, 2'd3, 2'd1, 2'd0};

  logic clk = 0, rst_n = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic reg_we = 0;
  logic spi_sck, spi_csn, spi_mosi, spi_miso;

  always #5 clk = ~clk;

  opmenu_spi_seq #(.BUF_BYTES(64), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) i_opmenu_spi_seq (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso));

  int n_checks = 0, n_fail = 0;
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd_pat(input int k); return 8'(k * 37 + 8'hC3); endfunction
  function automatic logic [7:0] wr_pat(input int k); return 8'(k * 11 + 8'h5A); endfunction

  // flash-side monitor and responder
  int nframes = 0, bitcnt = 0, len0 = 0, len1 = 0, hdr_cur = 8;
  logic cap0 [600];
  logic cap1 [600];
  longint t_sck_rise = 0, half_ns = 0, t_cs_rise = 0, gap_ns = 0;

  always @(negedge spi_csn) begin bitcnt = 0; gap_ns = $time - t_cs_rise; end
  always @(posedge spi_csn) begin
    if (nframes == 0) len0 = bitcnt; else len1 = bitcnt;
    nframes++;
    t_cs_rise = $time;
  end
  always @(posedge spi_sck) begin
    if (bitcnt < 600) begin
      if (nframes == 0) cap0[bitcnt] = spi_mosi; else cap1[bitcnt] = spi_mosi;
    end
    bitcnt++;
    t_sck_rise = $time;
  end
  always @(negedge spi_sck) half_ns = $time - t_sck_rise;
  always @* begin
    if (bitcnt < hdr_cur) spi_miso = 1'b0;
    else spi_miso = rd_pat((bitcnt - hdr_cur) / 8)[7 - ((bitcnt - hdr_cur) % 8)];
  end

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1;
    @(negedge clk); reg_we = 0;
  endtask
  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_we = 0; #1 d = reg_rdata;
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      reg_read(A_STAT, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input int idx, input int cnt, input bit dat, input bit dirw,
                                          input bit pfx, input bit psel, input bit fast);
    return 32'(1 | (int'(pfx) << 1) | (int'(psel) << 2) | (int'(fast) << 3) | (idx << 4) |
               (cnt << 8) | (int'(dat) << 14) | (int'(dirw) << 15));
  endfunction
  function automatic int hdr_of(input int idx); return TYPES[idx][1] ? 32 : 8; endfunction
  function automatic int len_of(input int idx, input int cnt, input bit dat);
    return hdr_of(idx) + (dat ? 8 * (cnt + 1) : 0);
  endfunction
  function automatic logic exp_bit(input int idx, input int i);
    int h = hdr_of(idx);
    if (i < 8) return MENU[idx][7 - i];
    if (i < h) return FADDR[23 - (i - 8)];
    if (!TYPES[idx][0]) return 1'b0;
    return wr_pat((i - h) / 8)[7 - ((i - h) % 8)];
  endfunction
  function automatic int mism0(input int idx, input int n);
    int m = 0;
    for (int i = 0; i < n; i++) if (cap0[i] !== exp_bit(idx, i)) m++;
    return m;
  endfunction
  task automatic load_buf();
    for (int w = 0; w < 16; w++)
      reg_write(5'(16 + w), {wr_pat(4*w+3), wr_pat(4*w+2), wr_pat(4*w+1), wr_pat(4*w)});
  endtask

  initial begin
    #(190000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, ty, mlo, mhi;
    repeat (3) @(negedge clk);
    // R1 reset state
    reg_read(A_STAT, d);
    check(d == 0, "R1 status after reset", d, 0);
    check(spi_csn === 1'b1 && spi_sck === 1'b0 && spi_mosi === 1'b0, "R1 bus idle",
          {spi_csn, spi_sck, spi_mosi}, 3'b100);
    rst_n = 1;
    repeat (2) @(negedge clk);

    ty = 0; mlo = 0; mhi = 0;
    for (int i = 0; i < 8; i++) begin
      ty[2*i +: 2] = TYPES[i];
      if (i < 4) mlo[8*i +: 8] = MENU[i]; else mhi[8*(i-4) +: 8] = MENU[i];
    end
    reg_write(A_TYPE, ty); reg_write(A_MLO, mlo); reg_write(A_MHI, mhi);
    reg_write(A_PFX, 32'h0650);
    reg_write(A_ADDR, 32'hFF123456);
    reg_read(A_ADDR, d);
    check(d == 32'h00123456, "R3 upper address bits ignored", d, 32'h00123456);

    // table-driven commands
    for (int v = 0; v < 8; v++) begin
      int idx = int'(VECS[v][9:7]);
      int cnt = int'(VECS[v][6:1]);
      bit dat = VECS[v][0];
      bit fast = v[0];
      int elen = len_of(idx, cnt, dat);
      load_buf();
      hdr_cur = hdr_of(idx);
      nframes = 0;
      reg_write(A_CTRL, mk_ctrl(idx, cnt, dat, TYPES[idx][0], 0, 0, fast));
      check(spi_csn == 1'b0, "R2 chip select low after GO", spi_csn, 0);
      reg_read(A_STAT, d);
      check(d[0] == 1'b1, "R2 busy after GO", d, 1);
      wait_idle();
      reg_read(A_STAT, d);
      check(d[1:0] == 2'b10 && spi_csn, "R5 done set at end of frame", d, 2);
      check(nframes == 1 && len0 == elen, "R4 frame bit count", len0, elen);
      check(mism0(idx, elen) == 0, "R3 opcode/address/data bits", mism0(idx, elen), 0);
      check(half_ns == (fast ? DIV_FAST : DIV_SLOW) * 10, "R10 SCK high time", 32'(half_ns),
            (fast ? DIV_FAST : DIV_SLOW) * 10);
      if (dat && !TYPES[idx][0]) begin
        for (int b = 0; b <= cnt; b++) begin
          reg_read(5'(16 + b / 4), d);
          check(d[8*(b%4) +: 8] == rd_pat(b), "R4 read byte captured", d[8*(b%4) +: 8], rd_pat(b));
        end
      end
      reg_write(A_STAT, 32'h2);
      reg_read(A_STAT, d);
      check(d[1] == 1'b0, "R5 done cleared by write-one", d, 0);
    end

    // R6 GO while busy
    nframes = 0; hdr_cur = 8;
    reg_write(A_CTRL, mk_ctrl(6, 0, 0, 0, 0, 0, 0));
    reg_write(A_CTRL, mk_ctrl(4, 0, 0, 0, 0, 0, 0));
    wait_idle();
    repeat (20) @(negedge clk);
    check(nframes == 1 && len0 == 8, "R6 no extra frame", nframes, 1);
    check(mism0(6, 8) == 0, "R6 first opcode kept", mism0(6, 8), 0);
    reg_write(A_STAT, 32'h2);

    // R7 prefix frames
    nframes = 0;
    reg_write(A_CTRL, mk_ctrl(5, 0, 0, 1, 1, 1, 0));
    wait_idle();
    check(nframes == 2 && len0 == 8 && len1 == 32, "R7 two frames", {nframes[7:0], len0[7:0], len1[7:0]},
          {8'd2, 8'd8, 8'd32});
    d = 0;
    for (int i = 0; i < 8; i++) d[7 - i] = cap0[i];
    check(d[7:0] == 8'h06, "R7 prefix select 1 opcode", d, 8'h06);
    check(gap_ns == DIV_SLOW * 10, "R7 chip-select gap", 32'(gap_ns), DIV_SLOW * 10);
    d = 0;
    for (int i = 0; i < 32; i++) if (cap1[i] !== exp_bit(5, i)) d++;
    check(d == 0, "R7 main frame after prefix", d, 0);
    nframes = 0;
    reg_write(A_CTRL, mk_ctrl(6, 0, 0, 1, 1, 0, 0));
    wait_idle();
    d = 0;
    for (int i = 0; i < 8; i++) d[7 - i] = cap0[i];
    check(d[7:0] == 8'h50 && nframes == 2, "R7 prefix select 0 opcode", d, 8'h50);
    reg_write(A_STAT, 32'h2);

    // R8 lock
    reg_write(A_STAT, 32'h8);
    reg_write(A_TYPE, 32'h0); reg_write(A_MLO, 32'h0); reg_write(A_MHI, 32'h0);
    reg_write(A_PFX, 32'h0); reg_write(A_STAT, 32'h0);
    reg_read(A_STAT, d);
    check(d[3] == 1'b1, "R8 lock sticky", d, 8);
    reg_read(A_TYPE, d);  check(d == ty, "R8 types frozen", d, ty);
    reg_read(A_MLO, d);   check(d == mlo, "R8 menu low frozen", d, mlo);
    reg_read(A_MHI, d);   check(d == mhi, "R8 menu high frozen", d, mhi);
    reg_read(A_PFX, d);   check(d == 32'h0650, "R8 prefix frozen", d, 32'h0650);

    // R9 direction clash under lock
    nframes = 0;
    reg_write(A_CTRL, mk_ctrl(0, 0, 1, 1, 0, 0, 0));
    reg_read(A_STAT, d);
    check(d[2:0] == 3'b100, "R9 error set, not busy", d, 4);
    repeat (40) @(negedge clk);
    check(nframes == 0 && spi_csn, "R9 no SPI traffic", nframes, 0);
    reg_write(A_STAT, 32'h4);
    reg_read(A_STAT, d);
    check(d[2] == 1'b0, "R5 error cleared by write-one", d, 0);
    hdr_cur = 32;
    reg_write(A_CTRL, mk_ctrl(0, 0, 1, 0, 0, 0, 0));
    wait_idle();
    reg_read(A_STAT, d);
    check(nframes == 1 && len0 == 40 && d[2] == 1'b0, "R9 matching direction runs while locked",
          len0, 40);
    reg_read(5'd16, d);
    check(d[7:0] == rd_pat(0), "R4 single-byte read", d[7:0], rd_pat(0));

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule